// File: doc/BRIEF.md
# Processor Trace Nibble Output FIFO

This block links a processor core to an external debug port. Each clock the core presents one execution event. The block shows that event as a 4-bit status code. Some events carry a value: an operand written for the debugger, or the target of a taken branch. The block queues that value and streams it out on a 4-bit data port. Before each transfer the status port shows a size marker. The value then follows one nibble per clock, least significant nibble first.

The queue has two 32-bit entries. When both entries hold data, the block raises a stall to the core. The stall stays high until the data port has taken up the last nibble of the oldest entry. A control input sets how many low-order bytes of a branch target are queued, from none up to the full address. Reset is asynchronous and active low, and its release is synchronised to the clock inside the block.

Top module: `trace_nibble_port`

## Requirements
- R1: After reset the status port and the data port read 0x0 and the stall output is low.
- R2: The status port shows a code one clock after an event is sampled. The codes are: continue (`ev_kind` 0) gives 0x0, begin instruction (1) gives 0x1, user-mode entry (2) gives 0x3, pulse or write-data (3) gives 0x4, taken branch (4) gives 0x5, return from exception (5) gives 0x7. `ev_kind` values 6 and 7 give 0x0. The codes 0x2 and 0x6 never appear.
- R3: The buffer holds two entries. `core_stall` is high exactly while both entries hold data. It falls on the clock edge at which the last nibble of the oldest entry is placed on the data port.
- R4: While `core_stall` is high, the inputs are ignored. Nothing is queued and no event code is shown.
- R5: A write-data event (`ev_kind` 3) with `ev_capture` 1 queues `ev_size`+1 bytes (`ev_size` 0..3 gives 1..4 bytes) of `ev_value`. With `ev_capture` 0 it is a pulse and queues nothing.
- R6: A taken branch (`ev_kind` 4) with `ev_capture` 1 queues the low bytes of `ev_value`. The byte count comes from `br_addr_bytes`: 0 gives none, 1 gives 1 byte, 2 gives 2 bytes, 3 gives 4 bytes.
- R7: Before each transfer, the status port shows the marker 0x8, 0x9, 0xA or 0xB for 1, 2, 3 or 4 bytes. The marker appears in the clock just before the first data nibble. In a cycle where an event code and a pending marker both want the status port, the event code is shown and the marker waits.
- R8: A transfer places 2×bytes nibbles on the data port in consecutive clocks, least significant nibble first.
- R9: The data port reads 0x0 in every clock in which no transfer nibble is shown, and this includes the marker clock.
- R10: Entries leave in the order they were queued. The next marker comes no earlier than the clock after the previous transfer's last nibble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_kind | input | 3 | Event of this cycle (0 continue, 1 instruction, 2 user entry, 3 pulse/write-data, 4 taken branch, 5 exception return) |
| ev_capture | input | 1 | Event carries a value to queue |
| ev_size | input | 2 | Write-data operand size, bytes minus one |
| ev_value | input | 32 | Operand or branch target |
| br_addr_bytes | input | 2 | Branch-target byte count setting |
| trc_status | output | 4 | Status / marker code |
| trc_data | output | 4 | Data nibble |
| core_stall | output | 1 | Stall request to the core |

## Verification
Event codes and markers appear on `trc_status` one edge after the inputs are sampled. A marker can come no earlier than one edge after the capture that queued its value. The first nibble follows the marker edge by one more edge. `core_stall` changes on the same edge as the push or pop that moves the entry count. The bench drives each input on a falling edge. It advances a reference model once for that coming rising edge and compares all three outputs on the next falling edge, so every comparison falls in the cycle in which the result is due.

// File: rtl/trace_pkg.sv
package trace_pkg;

  typedef enum logic [2:0] {
    EV_CONT   = 3'd0,
    EV_INSN   = 3'd1,
    EV_USER   = 3'd2,
    EV_WRITE  = 3'd3,
    EV_BRANCH = 3'd4,
    EV_RTE    = 3'd5
  } ev_kind_e;

  localparam logic [3:0] ST_CONT      = 4'h0;
  localparam logic [3:0] ST_INSN      = 4'h1;
  localparam logic [3:0] ST_USER      = 4'h3;
  localparam logic [3:0] ST_WRITE     = 4'h4;
  localparam logic [3:0] ST_BRANCH    = 4'h5;
  localparam logic [3:0] ST_RTE       = 4'h7;
  localparam logic [3:0] ST_MARK_BASE = 4'h8;

endpackage

// File: rtl/trace_capture.sv
module trace_capture
  import trace_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [2:0]    ev_kind,
  input  logic          ev_capture,
  input  logic [1:0]    ev_size,
  input  logic [DW-1:0] ev_value,
  input  logic [1:0]    br_bytes,
  input  logic          stall,
  output logic          ev_live,
  output logic [3:0]    ev_code,
  output logic          push,
  output logic [DW-1:0] push_value,
  output logic [1:0]    push_sz
);

  logic [1:0] br_sz;

  // branch setting 1 -> 1 byte, 2 -> 2 bytes, 3 -> 4 bytes
  assign br_sz      = (br_bytes == 2'd3) ? 2'd3 : (br_bytes - 2'd1);
  assign push_value = ev_value;

  always_comb begin
    ev_live = 1'b0;
    ev_code = ST_CONT;
    push    = 1'b0;
    push_sz = ev_size;
    if (!stall) begin
      case (ev_kind_e'(ev_kind))
        EV_INSN: begin
          ev_live = 1'b1;
          ev_code = ST_INSN;
        end
        EV_USER: begin
          ev_live = 1'b1;
          ev_code = ST_USER;
        end
        EV_WRITE: begin
          ev_live = 1'b1;
          ev_code = ST_WRITE;
          push    = ev_capture;
          push_sz = ev_size;
        end
        EV_BRANCH: begin
          ev_live = 1'b1;
          ev_code = ST_BRANCH;
          push    = ev_capture && (br_bytes != 2'd0);
          push_sz = br_sz;
        end
        EV_RTE: begin
          ev_live = 1'b1;
          ev_code = ST_RTE;
        end
        default: begin
          ev_live = 1'b0;
          ev_code = ST_CONT;
        end
      endcase
    end
  end

endmodule

// File: rtl/trace_fifo.sv
module trace_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 2
) (
  input  logic                       clk,
  input  logic                       arst_n,
  input  logic                       push,
  input  logic [DW-1:0]              push_value,
  input  logic [1:0]                 push_sz,
  input  logic                       pop,
  output logic                       head_valid,
  output logic [DW-1:0]              head_value,
  output logic [1:0]                 head_sz,
  output logic                       full,
  output logic [$clog2(DEPTH+1)-1:0] count
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [DW-1:0] val_q [DEPTH];
  logic [1:0]    sz_q  [DEPTH];
  logic [PW-1:0] wr_ptr_q, wr_ptr_d;
  logic [PW-1:0] rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    logic wr_en;
    assign wr_en = push && (wr_ptr_q == PW'(i));
    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
        val_q[i] <= '0;
        sz_q[i]  <= '0;
      end else if (wr_en) begin
        val_q[i] <= push_value;
        sz_q[i]  <= push_sz;
      end
    end
  end

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (push) begin
      wr_ptr_d = (wr_ptr_q == PW'(DEPTH-1)) ? '0 : wr_ptr_q + PW'(1);
    end
    if (pop) begin
      rd_ptr_d = (rd_ptr_q == PW'(DEPTH-1)) ? '0 : rd_ptr_q + PW'(1);
    end
    if (push && !pop) begin
      cnt_d = cnt_q + CW'(1);
    end else if (pop && !push) begin
      cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  assign head_valid = (cnt_q != '0);
  assign head_value = val_q[rd_ptr_q];
  assign head_sz    = sz_q[rd_ptr_q];
  assign full       = (cnt_q == CW'(DEPTH));
  assign count      = cnt_q;

endmodule

// File: rtl/trace_drain.sv
module trace_drain
  import trace_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          head_valid,
  input  logic [DW-1:0] head_value,
  input  logic [1:0]    head_sz,
  input  logic          ev_live,
  input  logic [3:0]    ev_code,
  output logic [3:0]    status_q,
  output logic [3:0]    data_q,
  output logic          pop,
  output logic          busy
);

  localparam int NW = $clog2(DW/4);

  logic          busy_q, busy_d;
  logic [NW-1:0] idx_q, idx_d;
  logic [NW-1:0] last_idx;
  logic          marker_go;
  logic [3:0]    status_d;
  logic [3:0]    data_d;
  logic [3:0]    cur_nib;

  assign last_idx = NW'({head_sz, 1'b1});
  assign cur_nib  = head_value[{idx_q, 2'b00} +: 4];

  always_comb begin
    marker_go = !ev_live && head_valid && !busy_q;
    pop       = busy_q && (idx_q == last_idx);
    if (ev_live) begin
      status_d = ev_code;
    end else if (marker_go) begin
      status_d = ST_MARK_BASE | {2'b00, head_sz};
    end else begin
      status_d = ST_CONT;
    end
    data_d = busy_q ? cur_nib : 4'h0;
    busy_d = busy_q;
    idx_d  = idx_q;
    if (marker_go) begin
      busy_d = 1'b1;
      idx_d  = '0;
    end else if (pop) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      idx_d = idx_q + NW'(1);
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      busy_q   <= 1'b0;
      idx_q    <= '0;
      status_q <= ST_CONT;
      data_q   <= 4'h0;
    end else begin
      busy_q   <= busy_d;
      idx_q    <= idx_d;
      status_q <= status_d;
      data_q   <= data_d;
    end
  end

  assign busy = busy_q;

endmodule

// File: rtl/trace_nibble_port.sv
module trace_nibble_port #(
  parameter int DW    = 32,
  parameter int DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    ev_kind,
  input  logic          ev_capture,
  input  logic [1:0]    ev_size,
  input  logic [DW-1:0] ev_value,
  input  logic [1:0]    br_addr_bytes,
  output logic [3:0]    trc_status,
  output logic [3:0]    trc_data,
  output logic          core_stall
);

  localparam int CW = $clog2(DEPTH+1);

  logic [1:0]    rst_pipe_q;
  logic          rst_sync_n;
  logic          ev_live;
  logic [3:0]    ev_code;
  logic          push;
  logic [DW-1:0] push_value;
  logic [1:0]    push_sz;
  logic          pop;
  logic          head_valid;
  logic [DW-1:0] head_value;
  logic [1:0]    head_sz;
  logic          full;
  logic [CW-1:0] fifo_count;
  logic          drain_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  trace_capture #(.DW(DW)) u_capture (
    .ev_kind    (ev_kind),
    .ev_capture (ev_capture),
    .ev_size    (ev_size),
    .ev_value   (ev_value),
    .br_bytes   (br_addr_bytes),
    .stall      (full),
    .ev_live    (ev_live),
    .ev_code    (ev_code),
    .push       (push),
    .push_value (push_value),
    .push_sz    (push_sz)
  );

  trace_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk        (clk),
    .arst_n     (rst_sync_n),
    .push       (push),
    .push_value (push_value),
    .push_sz    (push_sz),
    .pop        (pop),
    .head_valid (head_valid),
    .head_value (head_value),
    .head_sz    (head_sz),
    .full       (full),
    .count      (fifo_count)
  );

  trace_drain #(.DW(DW)) u_drain (
    .clk        (clk),
    .arst_n     (rst_sync_n),
    .head_valid (head_valid),
    .head_value (head_value),
    .head_sz    (head_sz),
    .ev_live    (ev_live),
    .ev_code    (ev_code),
    .status_q   (trc_status),
    .data_q     (trc_data),
    .pop        (pop),
    .busy       (drain_busy)
  );

  assign core_stall = full;

endmodule

// File: rtl/trace_nibble_port_chk.sv
module trace_nibble_port_chk #(
  parameter int DEPTH = 2
) (
  input logic                       clk,
  input logic                       arst_n,
  input logic [3:0]                 trc_status,
  input logic [3:0]                 trc_data,
  input logic                       core_stall,
  input logic                       push,
  input logic                       pop,
  input logic                       head_valid,
  input logic [$clog2(DEPTH+1)-1:0] fifo_count,
  input logic                       busy
);

  localparam int CW = $clog2(DEPTH+1);

  AST_NO_RESERVED_CODE: assert property (@(posedge clk) disable iff (!arst_n)
    (trc_status != 4'h2) && (trc_status != 4'h6)); // R2

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!arst_n)
    fifo_count <= CW'(DEPTH)); // R3

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!arst_n)
    (core_stall && !pop) |=> core_stall); // R3

  AST_NO_PUSH_WHEN_STALLED: assert property (@(posedge clk) disable iff (!arst_n)
    core_stall |-> !push); // R4

  AST_MARKER_STARTS_TRANSFER: assert property (@(posedge clk) disable iff (!arst_n)
    trc_status[3] |-> busy); // R7

  AST_MARKER_QUIET_DATA: assert property (@(posedge clk) disable iff (!arst_n)
    trc_status[3] |-> (trc_data == 4'h0)); // R9

  AST_POP_NEEDS_DATA: assert property (@(posedge clk) disable iff (!arst_n)
    pop |-> head_valid); // R10

endmodule

bind trace_nibble_port trace_nibble_port_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .arst_n     (rst_sync_n),
  .trc_status (trc_status),
  .trc_data   (trc_data),
  .core_stall (core_stall),
  .push       (push),
  .pop        (pop),
  .head_valid (head_valid),
  .fifo_count (fifo_count),
  .busy       (drain_busy)
);

// File: tb/trace_nibble_port_test.sv
`timescale 1ns/1ps
module trace_nibble_port_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  ev_kind;
  logic        ev_capture;
  logic [1:0]  ev_size;
  logic [31:0] ev_value;
  logic [1:0]  br_addr_bytes;
  logic [3:0]  trc_status;
  logic [3:0]  trc_data;
  logic        core_stall;

  int    n_checks = 0;
  int    n_fail   = 0;
  string cur_tag  = "R1";

  logic [31:0] m_val [2];
  logic [1:0]  m_sz  [2];
  int          m_cnt  = 0;
  bit          m_busy = 0;
  int          m_idx  = 0;

  always #4 clk = ~clk;

  trace_nibble_port uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .ev_kind       (ev_kind),
    .ev_capture    (ev_capture),
    .ev_size       (ev_size),
    .ev_value      (ev_value),
    .br_addr_bytes (br_addr_bytes),
    .trc_status    (trc_status),
    .trc_data      (trc_data),
    .core_stall    (core_stall)
  );

  task automatic check(string what, logic [3:0] act, logic [3:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%h expected 0x%h at %0t", cur_tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] code_of(int k);
    case (k)
      1: return 4'h1;
      2: return 4'h3;
      3: return 4'h4;
      4: return 4'h5;
      5: return 4'h7;
      default: return 4'h0;
    endcase
  endfunction

  function automatic logic [1:0] br_sz_of(logic [1:0] b);
    return (b == 2'd3) ? 2'd3 : (b - 2'd1);
  endfunction

  // One cycle: entered and left on a falling edge
  task automatic step(int k, bit cap, logic [1:0] sz, logic [31:0] v);
    bit         full, live, mgo, psh;
    logic [1:0] psz;
    logic [3:0] e_pst, e_dat;
    full = (m_cnt == 2);
    check("R3 stall", {3'b000, core_stall}, {3'b000, full});
    ev_kind    = 3'(k);
    ev_capture = cap;
    ev_size    = sz;
    ev_value   = v;
    live  = !full && (k >= 1) && (k <= 5);
    mgo   = !live && (m_cnt > 0) && !m_busy;
    e_pst = live ? code_of(k) : (mgo ? (4'h8 + {2'b00, m_sz[0]}) : 4'h0);
    e_dat = m_busy ? m_val[0][m_idx*4 +: 4] : 4'h0;
    psh = 0;
    psz = sz;
    if (live && cap && k == 3) psh = 1;
    if (live && cap && k == 4 && br_addr_bytes != 2'd0) begin
      psh = 1;
      psz = br_sz_of(br_addr_bytes);
    end
    if (m_busy) begin
      if (m_idx == 2*int'(m_sz[0]) + 1) begin
        m_val[0] = m_val[1];
        m_sz[0]  = m_sz[1];
        m_cnt--;
        m_busy = 0;
      end else begin
        m_idx++;
      end
    end
    if (mgo) begin
      m_busy = 1;
      m_idx  = 0;
    end
    if (psh) begin
      m_val[m_cnt] = v;
      m_sz[m_cnt]  = psz;
      m_cnt++;
    end
    @(posedge clk);
    @(negedge clk);
    check("R2 R7 status", trc_status, e_pst);
    check("R8 R9 data", trc_data, e_dat);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 2'd0, 32'h0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    ev_kind = 3'd0; ev_capture = 1'b0; ev_size = 2'd0; ev_value = 32'h0;
    br_addr_bytes = 2'd3;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: state after reset
    cur_tag = "R1";
    check("R1 status", trc_status, 4'h0);
    check("R1 data", trc_data, 4'h0);
    check("R1 stall", {3'b000, core_stall}, 4'h0);
    idle(2);

    // R2: every event kind, including the unused ones
    cur_tag = "R2";
    for (int k = 0; k < 8; k++) step(k, 0, 2'd0, 32'h0);
    idle(2);

    // R5: write-data sizes 1..4 bytes, then a pulse that queues nothing
    cur_tag = "R5";
    for (int s = 0; s < 4; s++) begin
      step(3, 1, 2'(s), 32'hA1B2C3D4 + 32'(s));
      idle(12);
    end
    step(3, 0, 2'd3, 32'hFFFFFFFF);
    idle(6);

    // R6: branch-target byte count settings 0..3
    cur_tag = "R6";
    for (int b = 0; b < 4; b++) begin
      br_addr_bytes = 2'(b);
      step(4, 1, 2'd0, 32'h87654321);
      idle(12);
    end

    // R7: an event in the marker's cycle wins the status port
    cur_tag = "R7";
    step(3, 1, 2'd1, 32'h00005A3C);
    step(1, 0, 2'd0, 32'h0);
    step(5, 0, 2'd0, 32'h0);
    idle(8);

    // R3 / R4: fill both entries, then events during the stall are dropped
    cur_tag = "R4";
    step(3, 1, 2'd3, 32'h13579BDF);
    step(3, 1, 2'd3, 32'h2468ACE0);
    for (int i = 0; i < 6; i++) step(4, 1, 2'd0, 32'hDEADBEEF);
    cur_tag = "R3";
    idle(24);

    // R10 / R8: back-to-back entries drain in order
    cur_tag = "R10";
    step(3, 1, 2'd0, 32'h000000C5);
    step(4, 1, 2'd0, 32'h0000F00D);
    idle(16);

    // Random traffic with all rules active
    cur_tag = "R8";
    for (int i = 0; i < 3000; i++) begin
      int k;
      if (($urandom % 40) == 0) br_addr_bytes = 2'($urandom % 4);
      k = (($urandom % 3) == 0) ? 0 : int'($urandom % 8);
      step(k, 1'($urandom % 2), 2'($urandom % 4), $urandom);
    end
    cur_tag = "R9";
    idle(24);
    finish_run();
  end

endmodule